// File: doc/BRIEF.md
# DS3 Frame Maintenance Out-of-Frame Monitor

This block sits behind an aligned DS3 receive framer and decides when the framer has lost alignment. For every F-bit and M-bit the framer has checked, it supplies a strobe and an error flag. Once per M-frame it supplies a strobe and a parity error flag. The monitor keeps a short history of each of the three overhead-bit types. It applies a selectable error threshold to each history and combines the enabled criteria with an OR into one Out-of-Frame (OOF) decision. When that decision first becomes true, the block raises its OOF status level and issues a one-cycle reframe request to the acquisition logic.

The control is a two-state machine. In `ST_HUNT` the framer is searching and OOF reads 1. In `ST_LOCKED` it is in frame and OOF reads 0. The monitor moves from `ST_LOCKED` to `ST_HUNT` (the *lose-lock* transition, which pulses the reframe request) when any enabled criterion holds. It moves from `ST_HUNT` to `ST_LOCKED` (the *acquire* transition) when the acquisition logic pulses `in_frame`. That pulse also empties all three histories. Reset puts the machine in `ST_HUNT`.

Configuration bits:
- `f_strict` tightens the F-bit threshold.
- `m_check` enables the M-bit criterion.
- `par_check` adds the parity criterion.

Top module: `ds3_oof_monitor`

## Requirements
- R1: A synchronous active-high `rst` sets `oof` to 1 and `reframe_req` to 0, and empties the F, M and P histories.
- R2: An `in_frame` pulse makes `oof` 0 after the next edge and empties all three histories, so errors seen before it no longer count. `in_frame` takes priority over a criterion that holds in the same cycle.
- R3: With `f_strict`=1, OOF is declared when 3 or more of the last 16 F-bits were in error; 2 errors do not declare it.
- R4: With `f_strict`=0, OOF is declared when 6 or more of the last 16 F-bits were in error; 5 errors do not declare it.
- R5: Histories slide: an error older than the window length (16 F, 4 M, 5 P entries) no longer counts toward a threshold.
- R6: With `m_check`=1, OOF is declared when 3 or more of the last 4 M-bits were in error; 2 errors do not declare it.
- R7: With `m_check`=0, M-bit errors never cause OOF.
- R8: With `par_check`=1, OOF is declared when 2 or more of the last 5 M-frames had a parity error; 1 error does not declare it.
- R9: With `par_check`=0, parity errors never cause OOF. The parity criterion is ORed with the F and M criteria and never replaces them.
- R10: A history advances only on its own strobe (`f_valid`, `m_valid`, `p_valid`); an error flag without its strobe is ignored.
- R11: When a criterion becomes true while locked, `oof` rises and `reframe_req` pulses for exactly one cycle, both on the second clock edge after the strobe that completed the count.
- R12: While in `ST_HUNT`, `oof` stays 1 and no further `reframe_req` is issued until `in_frame` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| f_valid | input | 1 | An F-bit result is present this cycle |
| f_err | input | 1 | That F-bit was in error |
| m_valid | input | 1 | An M-bit result is present this cycle |
| m_err | input | 1 | That M-bit was in error |
| p_valid | input | 1 | A per-M-frame parity result is present this cycle |
| p_err | input | 1 | That M-frame had a parity error |
| f_strict | input | 1 | 1: F threshold 3 of 16; 0: F threshold 6 of 16 |
| m_check | input | 1 | 1: M threshold 3 of 4; 0: M errors ignored |
| par_check | input | 1 | 1: parity threshold 2 of 5 added; 0: parity ignored |
| in_frame | input | 1 | Pulse from acquisition: frame found, clear OOF and histories |
| oof | output | 1 | Out-of-Frame status level (1 = declared) |
| reframe_req | output | 1 | One-cycle request to start a new frame search |

## Verification
Directed sequences place each threshold at exactly one below its count and then exactly at it. Because the three criteria are driven separately, a miscount in one history cannot be hidden by the others. The aging sequences (errors pushed out by clean entries) tell a sliding window apart from a sticky counter. Strobe-free error flags, the disabled M and parity settings, and an `in_frame` pulse after near-threshold errors tell filtering and flushing apart from plain counting. A long seeded random run then mixes strobes, error flags, configuration changes, `in_frame` pulses and resets against a bench reference model, compared every cycle.

// File: rtl/ds3_oof_pkg.sv
package ds3_oof_pkg;
    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } oof_state_e;
endpackage

// File: rtl/ds3_err_window.sv
module ds3_err_window #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          valid,
    input  logic          err,
    output logic [CW-1:0] count
);
    logic [DEPTH-1:0] hist;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            hist <= '0;
        end else if (valid) begin
            hist <= {hist[DEPTH-2:0], err};
        end
    end

    always_comb begin
        count = '0;
        for (int i = 0; i < DEPTH; i++) begin
            count = count + CW'(hist[i]);
        end
    end

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0)); // R2
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!valid && !flush) |=> $stable(count)); // R10
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (valid && !flush) |=> (count <= $past(count) + CW'(1))); // R5
endmodule

// File: rtl/ds3_oof_criteria.sv
module ds3_oof_criteria #(
    parameter int F_DEPTH   = 16,
    parameter int M_DEPTH   = 4,
    parameter int P_DEPTH   = 5,
    parameter int F_TIGHT   = 3,
    parameter int F_LOOSE   = 6,
    parameter int M_LIMIT   = 3,
    parameter int P_LIMIT   = 2,
    localparam int FCW = $clog2(F_DEPTH + 1),
    localparam int MCW = $clog2(M_DEPTH + 1),
    localparam int PCW = $clog2(P_DEPTH + 1)
) (
    input  logic [FCW-1:0] f_cnt,
    input  logic [MCW-1:0] m_cnt,
    input  logic [PCW-1:0] p_cnt,
    input  logic           f_strict,
    input  logic           m_check,
    input  logic           par_check,
    output logic           trip
);
    localparam logic [FCW-1:0] F_T = FCW'(F_TIGHT);
    localparam logic [FCW-1:0] F_L = FCW'(F_LOOSE);
    localparam logic [MCW-1:0] M_T = MCW'(M_LIMIT);
    localparam logic [PCW-1:0] P_T = PCW'(P_LIMIT);

    logic f_hit, m_hit, p_hit;

    always_comb begin
        f_hit = (f_cnt >= (f_strict ? F_T : F_L));
        m_hit = m_check && (m_cnt >= M_T);
        p_hit = par_check && (p_cnt >= P_T);
        trip  = f_hit || m_hit || p_hit;
    end
endmodule

// File: rtl/ds3_oof_fsm.sv
module ds3_oof_fsm
    import ds3_oof_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trip,
    input  logic in_frame,
    output logic oof,
    output logic reframe_req
);
    oof_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:   if (in_frame) state_nx = ST_LOCKED;
            ST_LOCKED: if (!in_frame && trip) state_nx = ST_HUNT;
            default:   state_nx = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_HUNT;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) reframe_req <= 1'b0;
        else     reframe_req <= (state == ST_LOCKED) && (state_nx == ST_HUNT);
    end

    assign oof = (state == ST_HUNT);

    AST_RESET_HUNT: assert property (@(posedge clk)
        rst |=> (oof && !reframe_req)); // R1
    AST_ACQUIRE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        in_frame |=> !oof); // R2
    AST_LOSE_LOCK: assert property (@(posedge clk) disable iff (rst)
        (trip && !oof && !in_frame) |=> (oof && reframe_req)); // R11
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        reframe_req |=> !reframe_req); // R11
    AST_HUNT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (oof && !in_frame) |=> (oof && !reframe_req)); // R12
endmodule

// File: rtl/ds3_oof_monitor.sv
module ds3_oof_monitor #(
    parameter int F_DEPTH = 16,
    parameter int M_DEPTH = 4,
    parameter int P_DEPTH = 5,
    parameter int F_TIGHT = 3,
    parameter int F_LOOSE = 6,
    parameter int M_LIMIT = 3,
    parameter int P_LIMIT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic f_valid,
    input  logic f_err,
    input  logic m_valid,
    input  logic m_err,
    input  logic p_valid,
    input  logic p_err,
    input  logic f_strict,
    input  logic m_check,
    input  logic par_check,
    input  logic in_frame,
    output logic oof,
    output logic reframe_req
);
    localparam int FCW = $clog2(F_DEPTH + 1);
    localparam int MCW = $clog2(M_DEPTH + 1);
    localparam int PCW = $clog2(P_DEPTH + 1);

    logic [FCW-1:0] f_cnt;
    logic [MCW-1:0] m_cnt;
    logic [PCW-1:0] p_cnt;
    logic           trip;

    ds3_err_window #(.DEPTH(F_DEPTH)) u_fwin (
        .clk(clk), .rst(rst), .flush(in_frame),
        .valid(f_valid), .err(f_err), .count(f_cnt));

    ds3_err_window #(.DEPTH(M_DEPTH)) u_mwin (
        .clk(clk), .rst(rst), .flush(in_frame),
        .valid(m_valid), .err(m_err), .count(m_cnt));

    ds3_err_window #(.DEPTH(P_DEPTH)) u_pwin (
        .clk(clk), .rst(rst), .flush(in_frame),
        .valid(p_valid), .err(p_err), .count(p_cnt));

    ds3_oof_criteria #(
        .F_DEPTH(F_DEPTH), .M_DEPTH(M_DEPTH), .P_DEPTH(P_DEPTH),
        .F_TIGHT(F_TIGHT), .F_LOOSE(F_LOOSE),
        .M_LIMIT(M_LIMIT), .P_LIMIT(P_LIMIT)
    ) u_crit (
        .f_cnt(f_cnt), .m_cnt(m_cnt), .p_cnt(p_cnt),
        .f_strict(f_strict), .m_check(m_check), .par_check(par_check),
        .trip(trip));

    ds3_oof_fsm u_fsm (
        .clk(clk), .rst(rst), .trip(trip), .in_frame(in_frame),
        .oof(oof), .reframe_req(reframe_req));

    AST_M_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!oof && !in_frame && !m_check && !par_check && !f_valid &&
         (f_cnt < FCW'(F_TIGHT))) |=> !reframe_req); // R7
endmodule

// File: tb/tb_ds3_oof_monitor.sv
module tb_ds3_oof_monitor;
    logic clk = 1'b0;
    logic rst, f_valid, f_err, m_valid, m_err, p_valid, p_err;
    logic f_strict, m_check, par_check, in_frame;
    logic oof, reframe_req;

    always #4 clk = ~clk;

    ds3_oof_monitor dut (
        .clk(clk), .rst(rst), .f_valid(f_valid), .f_err(f_err),
        .m_valid(m_valid), .m_err(m_err), .p_valid(p_valid), .p_err(p_err),
        .f_strict(f_strict), .m_check(m_check), .par_check(par_check),
        .in_frame(in_frame), .oof(oof), .reframe_req(reframe_req));

    int vectors = 0;
    int errors  = 0;
    string tag = "R1";

    // reference model
    logic [15:0] mf;
    logic [3:0]  mm;
    logic [4:0]  mp;
    logic        m_oof, m_req;

    function automatic logic ref_trip(logic [15:0] fh, logic [3:0] mh, logic [4:0] ph,
                                      logic fs, logic mc, logic pc);
        int fthr;
        fthr = fs ? 3 : 6;
        return ($countones(fh) >= fthr) || (mc && $countones(mh) >= 3) ||
               (pc && $countones(ph) >= 2);
    endfunction

    task automatic model_edge();
        logic t;
        t = ref_trip(mf, mm, mp, f_strict, m_check, par_check);
        if (rst) begin
            m_oof = 1'b1; m_req = 1'b0; mf = '0; mm = '0; mp = '0;
        end else begin
            m_req = !m_oof && !in_frame && t;
            if (in_frame) m_oof = 1'b0;
            else if (t)   m_oof = 1'b1;
            if (in_frame) begin
                mf = '0; mm = '0; mp = '0;
            end else begin
                if (f_valid) mf = {mf[14:0], f_err};
                if (m_valid) mm = {mm[2:0], m_err};
                if (p_valid) mp = {mp[3:0], p_err};
            end
        end
    endtask

    task automatic compare();
        vectors++;
        if (oof !== m_oof || reframe_req !== m_req) begin
            errors++;
            $display("FAIL %s: oof/req actual %b%b expected %b%b at %0t",
                     tag, oof, reframe_req, m_oof, m_req, $time);
        end
    endtask

    task automatic expect_out(string t, logic eo, logic er);
        vectors++;
        if (oof !== eo || reframe_req !== er) begin
            errors++;
            $display("FAIL %s: oof/req actual %b%b expected %b%b", t, oof, reframe_req, eo, er);
        end
    endtask

    task automatic clear_in();
        rst = 0; f_valid = 0; f_err = 0; m_valid = 0; m_err = 0;
        p_valid = 0; p_err = 0; in_frame = 0;
    endtask

    task automatic step();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        compare();
        clear_in();
    endtask

    task automatic f_bit(logic e); f_valid = 1; f_err = e; step(); endtask
    task automatic m_bit(logic e); m_valid = 1; m_err = e; step(); endtask
    task automatic p_bit(logic e); p_valid = 1; p_err = e; step(); endtask
    task automatic idle(int n); for (int i = 0; i < n; i++) step(); endtask
    task automatic lock(); in_frame = 1; step(); endtask
    task automatic cfg(logic fs, logic mc, logic pc);
        f_strict = fs; m_check = mc; par_check = pc;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5EED_0D53;
        void'($urandom(seed));
        clear_in(); cfg(1, 0, 0);
        mf = '0; mm = '0; mp = '0; m_oof = 1; m_req = 0;
        @(negedge clk);
        rst = 1; tag = "R1"; step();
        expect_out("R1", 1'b1, 1'b0);

        tag = "R2"; lock(); expect_out("R2", 1'b0, 1'b0);

        // R3: tight F threshold
        tag = "R3";
        f_bit(1); f_bit(0); f_bit(1); idle(2);
        expect_out("R3", 1'b0, 1'b0);
        f_bit(1);
        expect_out("R3", 1'b0, 1'b0);
        idle(1);
        expect_out("R11", 1'b1, 1'b1);
        idle(1);
        expect_out("R11", 1'b1, 1'b0);

        // R12: stays in hunt
        tag = "R12";
        for (int i = 0; i < 6; i++) f_bit(1);
        idle(10);
        expect_out("R12", 1'b1, 1'b0);

        // R2: flush of near-threshold history
        tag = "R2";
        lock(); f_bit(1); f_bit(1); lock();
        f_bit(1); idle(2);
        expect_out("R2", 1'b0, 1'b0);
        in_frame = 1; f_valid = 1; f_err = 1; step(); idle(2);
        expect_out("R2", 1'b0, 1'b0);

        // R4: loose F threshold
        tag = "R4"; cfg(0, 0, 0); lock();
        for (int i = 0; i < 5; i++) f_bit(1);
        idle(2); expect_out("R4", 1'b0, 1'b0);
        f_bit(1); idle(1); expect_out("R4", 1'b1, 1'b1);

        // R5: aging of F history
        tag = "R5"; cfg(1, 0, 0); lock();
        f_bit(1); f_bit(1);
        for (int i = 0; i < 16; i++) f_bit(0);
        f_bit(1); f_bit(1); idle(2);
        expect_out("R5", 1'b0, 1'b0);

        // R10: error flag without strobe
        tag = "R10"; lock(); f_bit(1); f_bit(1);
        for (int i = 0; i < 5; i++) begin f_err = 1; m_err = 1; step(); end
        expect_out("R10", 1'b0, 1'b0);

        // R6: M threshold
        tag = "R6"; cfg(0, 1, 0); lock();
        m_bit(1); m_bit(0); m_bit(1); idle(2);
        expect_out("R6", 1'b0, 1'b0);
        m_bit(1); idle(1); expect_out("R6", 1'b1, 1'b1);

        // R7: M ignored
        tag = "R7"; cfg(0, 0, 0); lock();
        for (int i = 0; i < 4; i++) m_bit(1);
        idle(3); expect_out("R7", 1'b0, 1'b0);

        // R8: parity threshold, with aging
        tag = "R8"; cfg(0, 0, 1); lock();
        p_bit(1);
        for (int i = 0; i < 4; i++) p_bit(0);
        p_bit(1); idle(2);
        expect_out("R8", 1'b0, 1'b0);
        p_bit(1); idle(1); expect_out("R8", 1'b1, 1'b1);

        // R9: parity ignored, F criterion still active
        tag = "R9"; cfg(1, 0, 0); lock();
        for (int i = 0; i < 5; i++) p_bit(1);
        idle(2); expect_out("R9", 1'b0, 1'b0);
        cfg(1, 0, 1); lock();
        f_bit(1); f_bit(1); f_bit(1); idle(1);
        expect_out("R9", 1'b1, 1'b1);

        // random mix checked against the model every cycle
        tag = "R11";
        for (int n = 0; n < 20000; n++) begin
            if (n % 500 == 0) cfg(1'($urandom), 1'($urandom), 1'($urandom));
            f_valid = ($urandom % 3) != 0;
            f_err   = ($urandom % 12) == 0;
            m_valid = ($urandom % 9) == 0;
            m_err   = ($urandom % 4) == 0;
            p_valid = ($urandom % 30) == 0;
            p_err   = ($urandom % 3) == 0;
            in_frame = oof ? (($urandom % 20) == 0) : (($urandom % 300) == 0);
            rst = ($urandom % 2000) == 0;
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule